// File: doc/BRIEF.md
# Serial Receiver with Error Flags

This block receives asynchronous serial characters from a single input line. The line is oversampled by a tick from a programmable divider. A start edge is qualified at the middle of the start bit, and each later bit is sampled at its own middle. Data arrives least significant bit first, with 7 or 8 data bits, an optional even or odd parity bit, and one stop bit. The assembled character moves into a data register. Four status flags report the outcome: data held, overrun, framing error and parity error.

Software reads the data register and the flags. It clears each flag with a one-cycle clear strobe. When errors coincide on one frame, a fixed priority decides two things: which flags are raised, and whether the character reaches the data register. An overrun never replaces the held character. A framing or parity error stores the character but leaves the data-held flag low. Two request outputs follow the flags: one for received data and one for errors.

Top module: `serial_rx_status`

## Requirements
- R1: A clean frame (start low, data least significant bit first, stop high) completing while all flags are low loads `rd_data` and sets `st_full`. `irq_rx` is high while `st_full` is high. After reset, all flags and `rd_data` read 0.
- R2: With `cfg_len7`=1, seven data bits are received. `rd_data[7]` reads 0.
- R3: The parity bit follows the data bits and is checked by `cfg_parity`: 2'b00 or 2'b11 means no parity bit, 2'b01 means even, 2'b10 means odd. A mismatching parity bit sets `st_par`.
- R4: A stop bit sampled low sets `st_frm`.
- R5: A framing error, a parity error, or both, on a frame that completes while all flags are low still loads `rd_data`. `st_full` stays 0.
- R6: A frame that completes while `st_full`=1 and no error flag is set raises `st_ovr` and leaves `st_full` at 1. `rd_data` keeps the earlier character. `st_frm` and `st_par` are raised by that frame's own framing and parity conditions.
- R7: While any of `st_ovr`, `st_frm` or `st_par` is set, completed frames change neither `rd_data` nor any flag.
- R8: A one-cycle pulse on a clear input drops the matching flag on the next clock. Once the flags are clear, reception resumes.
- R9: A low pulse on `rxd` shorter than half a bit returns the receiver to idle without producing a frame. The next real frame is received correctly.
- R10: `irq_err` is high while any of `st_ovr`, `st_frm`, `st_par` is high.
- R11: One oversampling tick occurs every `cfg_div`+1 clocks. One bit lasts 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| cfg_div | input | DIV_W | Tick divider; tick period is cfg_div+1 clocks |
| cfg_parity | input | 2 | 00/11 none, 01 even, 10 odd |
| cfg_len7 | input | 1 | 1 selects DATA_W-1 data bits |
| clr_full | input | 1 | Clear strobe for st_full |
| clr_ovr | input | 1 | Clear strobe for st_ovr |
| clr_frm | input | 1 | Clear strobe for st_frm |
| clr_par | input | 1 | Clear strobe for st_par |
| rd_data | output | DATA_W | Received character |
| st_full | output | 1 | Data-held flag |
| st_ovr | output | 1 | Overrun flag |
| st_frm | output | 1 | Framing error flag |
| st_par | output | 1 | Parity error flag |
| irq_rx | output | 1 | Receive request |
| irq_err | output | 1 | Error request |

## Verification
The hardest case to reach from the ports is a single frame that carries overrun, framing and parity errors at once. It needs an unread character already held, no error flag pending, and then a frame with both a corrupted parity bit and a low stop bit. The bench reaches it by sending a good frame, leaving `st_full` set, and then sending a deliberately malformed frame. It then checks that the first character survives. A low stop bit leaves the line low past the stop sample, so the bench idles long enough for any false start that follows to drain before it sends the next stimulus.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   typedef enum logic [1:0] {
      PM_NONE  = 2'b00,
      PM_EVEN  = 2'b01,
      PM_ODD   = 2'b10,
      PM_NONE3 = 2'b11
   } par_mode_e;

   typedef struct packed {
      logic [7:0] data;
      logic       frm_err;
      logic       par_err;
   } rx_result_t;

endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   // R11
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (div == '0) || !tick);

endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx,
   input  logic [1:0] par_mode,
   input  logic       len_short,
   output logic       done,
   output rx_result_t result
);

   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);

   rx_state_e         state_q;
   logic [CNT_W-1:0]  tcnt_q;
   logic [BIT_W-1:0]  bcnt_q;
   logic [DATA_W-1:0] sh_q;
   logic              pbit_q;
   logic              done_q;
   rx_result_t        res_q;

   logic              par_en;
   logic              par_odd;
   logic [BIT_W-1:0]  last_bit;
   logic [DATA_W-1:0] dout;
   logic              bit_mid;
   logic              par_expect;

   assign par_en     = (par_mode == PM_EVEN) || (par_mode == PM_ODD);
   assign par_odd    = (par_mode == PM_ODD);
   assign last_bit   = len_short ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1);
   assign dout       = len_short ? {1'b0, sh_q[DATA_W-1:1]} : sh_q;
   assign bit_mid    = tick && (tcnt_q == FULL_LAST);
   assign par_expect = (^dout) ^ par_odd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         tcnt_q  <= '0;
         bcnt_q  <= '0;
         sh_q    <= '0;
         pbit_q  <= 1'b0;
         done_q  <= 1'b0;
         res_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (tick && !bit_mid)
            tcnt_q <= tcnt_q + 1'b1;
         unique case (state_q)
            RX_IDLE: begin
               if (tick && !rx) begin
                  state_q <= RX_START;
                  tcnt_q  <= '0;
               end
            end
            RX_START: begin
               if (tick && tcnt_q == HALF_LAST) begin
                  tcnt_q <= '0;
                  bcnt_q <= '0;
                  state_q <= rx ? RX_IDLE : RX_DATA;
               end
            end
            RX_DATA: begin
               if (bit_mid) begin
                  tcnt_q <= '0;
                  sh_q   <= {rx, sh_q[DATA_W-1:1]};
                  bcnt_q <= bcnt_q + 1'b1;
                  if (bcnt_q == last_bit)
                     state_q <= par_en ? RX_PAR : RX_STOP;
               end
            end
            RX_PAR: begin
               if (bit_mid) begin
                  tcnt_q  <= '0;
                  pbit_q  <= rx;
                  state_q <= RX_STOP;
               end
            end
            RX_STOP: begin
               if (bit_mid) begin
                  tcnt_q        <= '0;
                  done_q        <= 1'b1;
                  res_q.data    <= 8'(dout);
                  res_q.frm_err <= !rx;
                  res_q.par_err <= par_en && (pbit_q != par_expect);
                  state_q       <= RX_IDLE;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   assign done   = done_q;
   assign result = res_q;

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R9
   false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_START && tick && tcnt_q == HALF_LAST && rx) |=> !done_q && state_q == RX_IDLE);

endmodule

// File: rtl/srx_status.sv
module srx_status
   import srx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  rx_result_t        result,
   input  logic              clr_full,
   input  logic              clr_ovr,
   input  logic              clr_frm,
   input  logic              clr_par,
   output logic [DATA_W-1:0] data_q,
   output logic              full_q,
   output logic              ovr_q,
   output logic              frm_q,
   output logic              par_q
);

   logic err_any;
   logic accept;

   assign err_any = ovr_q || frm_q || par_q;
   assign accept  = done && !err_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
         frm_q  <= 1'b0;
         par_q  <= 1'b0;
      end else begin
         if (clr_full) full_q <= 1'b0;
         if (clr_ovr)  ovr_q  <= 1'b0;
         if (clr_frm)  frm_q  <= 1'b0;
         if (clr_par)  par_q  <= 1'b0;
         if (accept && full_q) begin
            ovr_q <= 1'b1;
            if (result.frm_err) frm_q <= 1'b1;
            if (result.par_err) par_q <= 1'b1;
         end else if (accept) begin
            data_q <= DATA_W'(result.data);
            if (result.frm_err || result.par_err) begin
               if (result.frm_err) frm_q <= 1'b1;
               if (result.par_err) par_q <= 1'b1;
            end else begin
               full_q <= 1'b1;
            end
         end
      end
   end

   // R5
   err_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !full_q && !err_any && (result.frm_err || result.par_err))
      |=> !full_q && data_q == DATA_W'($past(result.data)));

   // R6
   ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && full_q && !err_any) |=> $stable(data_q) && ovr_q);

   // R7
   inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_any) |=> $stable(data_q));

   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_par && !done) |=> !par_q);

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
   import srx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int DIV_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [1:0]        cfg_parity,
   input  logic              cfg_len7,
   input  logic              clr_full,
   input  logic              clr_ovr,
   input  logic              clr_frm,
   input  logic              clr_par,
   output logic [DATA_W-1:0] rd_data,
   output logic              st_full,
   output logic              st_ovr,
   output logic              st_frm,
   output logic              st_par,
   output logic              irq_rx,
   output logic              irq_err
);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (DATA_W < 2 || DATA_W > 8) begin : g_bad_width
      $error("DATA_W must be in 2..8");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic       tick;
   logic       rx_s;
   logic       done;
   rx_result_t result;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = rxd;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sync_q <= '1;
         else
            sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], rxd} >> 0;
      end
      assign rx_s = sync_q[SYNC_STAGES-1];
   end

   srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .div   (cfg_div),
      .tick  (tick)
   );

   srx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .rx        (rx_s),
      .par_mode  (cfg_parity),
      .len_short (cfg_len7),
      .done      (done),
      .result    (result)
   );

   srx_status #(.DATA_W(DATA_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done),
      .result   (result),
      .clr_full (clr_full),
      .clr_ovr  (clr_ovr),
      .clr_frm  (clr_frm),
      .clr_par  (clr_par),
      .data_q   (rd_data),
      .full_q   (st_full),
      .ovr_q    (st_ovr),
      .frm_q    (st_frm),
      .par_q    (st_par)
   );

   assign irq_rx  = st_full;
   assign irq_err = st_ovr || st_frm || st_par;

endmodule

// File: tb/serial_rx_status_bench.sv
module serial_rx_status_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rxd = 1'b1;
   logic [11:0] cfg_div = 12'd1;
   logic [1:0]  cfg_parity = 2'b00;
   logic        cfg_len7 = 1'b0;
   logic        clr_full = 1'b0;
   logic        clr_ovr = 1'b0;
   logic        clr_frm = 1'b0;
   logic        clr_par = 1'b0;
   logic [7:0]  rd_data;
   logic        st_full, st_ovr, st_frm, st_par, irq_rx, irq_err;

   int nchk = 0;
   int nerr = 0;
   int bitclk = 32;
   int cyc = 0;
   bit done_run = 0;

   always #10 clk = ~clk;

   serial_rx_status u_serial_rx_status (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_div(cfg_div),
      .cfg_parity(cfg_parity), .cfg_len7(cfg_len7),
      .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_frm(clr_frm), .clr_par(clr_par),
      .rd_data(rd_data), .st_full(st_full), .st_ovr(st_ovr), .st_frm(st_frm),
      .st_par(st_par), .irq_rx(irq_rx), .irq_err(irq_err)
   );

   function automatic logic [3:0] flags();
      return {st_full, st_ovr, st_frm, st_par};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic drive_bit(input logic b);
      rxd = b;
      repeat (bitclk) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic len7, input logic [1:0] pm,
                       input logic bad_par, input logic stop_b);
      logic [7:0] dv;
      logic p;
      cfg_len7 = len7;
      cfg_parity = pm;
      dv = len7 ? {1'b0, d[6:0]} : d;
      drive_bit(1'b0);
      for (int i = 0; i < (len7 ? 7 : 8); i++) drive_bit(dv[i]);
      if (pm == 2'b01 || pm == 2'b10) begin
         p = (^dv) ^ (pm == 2'b10);
         if (bad_par) p = ~p;
         drive_bit(p);
      end
      drive_bit(stop_b);
      rxd = 1'b1;
      repeat ((stop_b ? 2 : 12) * bitclk) @(negedge clk);
   endtask

   task automatic clr_all();
      clr_full = 1; clr_ovr = 1; clr_frm = 1; clr_par = 1;
      @(negedge clk);
      clr_full = 0; clr_ovr = 0; clr_frm = 0; clr_par = 0;
   endtask

   task automatic pulse_full();
      clr_full = 1;
      @(negedge clk);
      clr_full = 0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done_run) begin
         nerr++;
         $display("FAIL watchdog all-reqs act=timeout exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] held;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      chk("R1 reset data", rd_data, 0);
      chk("R1 reset flags", flags(), 4'b0000);
      chk("R10 reset irq_err", irq_err, 0);

      // R1 sweep, 8 bits no parity
      for (int i = 0; i < 26; i++) begin
         v = (i == 24) ? 8'h00 : (i == 25) ? 8'hff : 8'((i * 53 + 17) & 255);
         send(v, 0, 2'b00, 0, 1);
         chk("R1 data", rd_data, v);
         chk("R1 flags", flags(), 4'b1000);
         chk("R1 irq_rx", irq_rx, 1);
         pulse_full();
         chk("R8 full cleared", flags(), 4'b0000);
      end

      // R2 R3 seven bits even parity
      for (int i = 0; i < 16; i++) begin
         v = 8'((i * 29 + 200) & 255);
         send(v, 1, 2'b01, 0, 1);
         chk("R2 data7", rd_data, {1'b0, v[6:0]});
         chk("R3 even flags", flags(), 4'b1000);
         pulse_full();
      end

      // R3 eight bits odd parity
      for (int i = 0; i < 16; i++) begin
         v = 8'((i * 71 + 3) & 255);
         send(v, 0, 2'b10, 0, 1);
         chk("R3 odd data", rd_data, v);
         chk("R3 odd flags", flags(), 4'b1000);
         pulse_full();
      end

      // R3 mode 11 means no parity bit
      send(8'h5a, 0, 2'b11, 0, 1);
      chk("R3 mode11 data", rd_data, 8'h5a);
      chk("R3 mode11 flags", flags(), 4'b1000);
      pulse_full();

      // R5 parity error alone
      send(8'h3c, 0, 2'b01, 1, 1);
      chk("R5 par data", rd_data, 8'h3c);
      chk("R3 par flags", flags(), 4'b0001);
      chk("R10 irq_err", irq_err, 1);
      chk("R1 irq_rx low", irq_rx, 0);
      // R7 inhibition
      send(8'hc3, 0, 2'b00, 0, 1);
      chk("R7 inhibit data", rd_data, 8'h3c);
      chk("R7 inhibit flags", flags(), 4'b0001);
      clr_par = 1; @(negedge clk); clr_par = 0;
      chk("R8 par cleared", flags(), 4'b0000);
      chk("R10 irq_err low", irq_err, 0);
      send(8'h99, 0, 2'b00, 0, 1);
      chk("R8 resume data", rd_data, 8'h99);
      chk("R8 resume flags", flags(), 4'b1000);
      pulse_full();

      // R4 R5 framing alone
      send(8'ha5, 0, 2'b00, 0, 0);
      chk("R5 frm data", rd_data, 8'ha5);
      chk("R4 frm flags", flags(), 4'b0010);
      clr_frm = 1; @(negedge clk); clr_frm = 0;
      chk("R8 frm cleared", flags(), 4'b0000);

      // R5 framing plus parity
      send(8'h71, 0, 2'b10, 1, 0);
      chk("R5 frm+par data", rd_data, 8'h71);
      chk("R5 frm+par flags", flags(), 4'b0011);
      clr_all();

      // R6 overrun alone
      send(8'h12, 0, 2'b00, 0, 1);
      send(8'h34, 0, 2'b00, 0, 1);
      chk("R6 ovr data", rd_data, 8'h12);
      chk("R6 ovr flags", flags(), 4'b1100);
      chk("R10 ovr irq_err", irq_err, 1);
      clr_all();

      // R6 overrun + framing + parity
      send(8'h56, 0, 2'b01, 0, 1);
      send(8'h78, 0, 2'b01, 1, 0);
      chk("R6 ovr3 data", rd_data, 8'h56);
      chk("R6 ovr3 flags", flags(), 4'b1111);
      clr_all();

      // R6 overrun + framing
      send(8'h0f, 0, 2'b00, 0, 1);
      send(8'hf0, 0, 2'b00, 0, 0);
      chk("R6 ovr+frm data", rd_data, 8'h0f);
      chk("R6 ovr+frm flags", flags(), 4'b1110);
      clr_all();
      chk("R8 all cleared", flags(), 4'b0000);

      // R9 glitch
      held = rd_data;
      rxd = 1'b0;
      repeat (6) @(negedge clk);
      rxd = 1'b1;
      repeat (12 * bitclk) @(negedge clk);
      chk("R9 glitch flags", flags(), 4'b0000);
      chk("R9 glitch data", rd_data, held);
      send(8'h6e, 0, 2'b00, 0, 1);
      chk("R9 after glitch data", rd_data, 8'h6e);
      pulse_full();

      // R11 slower divider
      cfg_div = 12'd3;
      bitclk = 64;
      repeat (8) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         v = 8'((i * 97 + 40) & 255);
         send(v, 0, 2'b01, 0, 1);
         chk("R11 div3 data", rd_data, v);
         chk("R11 div3 flags", flags(), 4'b1000);
         pulse_full();
      end

      done_run = 1;
      summary();
      $finish;
   end

endmodule